// File: doc/BRIEF.md
# Charge Pump Phase Sequencer

This block is the digital controller of a dual-output charge pump that builds a positive and a negative supply rail. It steps the pump's capacitor switches through a fixed four-phase cycle: charge storage for the negative rail, transfer to the negative rail, charge storage for the positive rail, then transfer to the positive rail. The cycle then repeats. Each phase lasts from one oscillator tick to the next. A single dead clock cycle, with every switch open, separates any two phases.

The pump runs discontinuously. A cycle is started only while at least one regulation comparator reports its rail below target. If both rails reach regulation in the middle of a cycle, the sequence still runs to the end of the fourth phase and stops there. A shutdown request opens every switch on the next clock. It also restarts a tick counter that raises a ready flag once the rails have had time to recover. The comparators are modelled as two digital flags.

Top module: `cp_phase_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `phase_o`, `sw_o`, `pump_active_o` and `pump_ready_o` are all 0.
- R2: Driven phases follow the order 1, 2, 3, 4, 1, ... and are reported on `phase_o`: bit k is set during phase k+1. A driven phase ends only at a clock where `tick_i` is high.
- R3: `sw_o` bits are: 0 first flying cap top to supply, 1 first flying cap bottom to ground, 2 first flying cap top to ground, 3 second flying cap top to supply, 4 second flying cap bottom to negative store, 5 second flying cap top to ground, 6 second flying cap bottom to ground, 7 second flying cap top to positive store. In phases 1 and 3 `sw_o` = 8'h0C, in phase 2 it is 8'h33, in phase 4 it is 8'hC3, and otherwise it is 8'h00.
- R4: At most one bit of `phase_o` is set. Every phase is entered through exactly one dead clock, in which `phase_o` and `sw_o` are 0. Such a clock comes between phases 1 and 2, between 2 and 3, between 3 and 4, and between 4 and 1.
- R5: When the pump is idle, a tick with `shdn_i` low and at least one of `pos_ok_i`/`neg_ok_i` low starts it: one dead clock, then phase 1. `pump_active_o` is high from the clock after that tick until the sequencer returns to idle.
- R6: At the tick that ends phase 4, the sequencer goes to idle if both flags are high. Otherwise it passes through a dead clock into phase 1. Flags that reach regulation during phases 1 to 3 do not shorten the cycle.
- R7: With `shdn_i` high at a clock edge, all outputs are 0 from that edge on. The sequencer is idle, and ticks are ignored while `shdn_i` stays high.
- R8: `pump_ready_o` rises on the clock of the READY_TICKS-th tick counted since reset or since the last clock with `shdn_i` high. Only ticks with `shdn_i` low count. It then stays high until shutdown or reset.
- R9: Ticks that arrive during a dead clock, or while idle with both flags high, have no effect on `phase_o`, `sw_o` or `pump_active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse from the divided phase oscillator |
| shdn_i | input | 1 | Shutdown request |
| pos_ok_i | input | 1 | Positive rail in regulation |
| neg_ok_i | input | 1 | Negative rail in regulation |
| phase_o | output | 4 | One-hot driven phase, 0 when dead or idle |
| sw_o | output | 8 | Capacitor switch enables |
| pump_active_o | output | 1 | Sequencer is not idle |
| pump_ready_o | output | 1 | Rail recovery time elapsed since shutdown release |

## Verification
A tick on every clock makes tick-paced phases as short as the dead cycle. This separates the one-clock dead slot from the tick-gated phase timing. Sparse, regularly spaced ticks combined with one low flag show continuous cycling. Raising both flags during phase 2 shows that the cycle is completed rather than cut short. Shutdown pulses dropped into the middle of phases separate immediate switch release from the ready counter restart. A long pseudo-random run mixes all inputs and checks the four-phase order and the stop decisions at arbitrary alignments.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned NUM_SW     = 8;
  localparam int unsigned PH_W       = $clog2(NUM_PHASES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEAD  = 2'd1,
    ST_DRIVE = 2'd2
  } seq_state_e;

  // switch bit positions
  localparam int unsigned SW_F1T_SUP = 0;
  localparam int unsigned SW_F1B_GND = 1;
  localparam int unsigned SW_F1T_GND = 2;
  localparam int unsigned SW_F2T_SUP = 3;
  localparam int unsigned SW_F2B_NEG = 4;
  localparam int unsigned SW_F2T_GND = 5;
  localparam int unsigned SW_F2B_GND = 6;
  localparam int unsigned SW_F2T_POS = 7;

  localparam logic [NUM_SW-1:0] CFG_STORE =
    NUM_SW'(1) << SW_F1T_GND | NUM_SW'(1) << SW_F2T_SUP;
  localparam logic [NUM_SW-1:0] CFG_F1_RST =
    NUM_SW'(1) << SW_F1T_SUP | NUM_SW'(1) << SW_F1B_GND;
  localparam logic [NUM_SW-1:0] CFG_NEG_XFER =
    CFG_F1_RST | NUM_SW'(1) << SW_F2B_NEG | NUM_SW'(1) << SW_F2T_GND;
  localparam logic [NUM_SW-1:0] CFG_POS_XFER =
    CFG_F1_RST | NUM_SW'(1) << SW_F2B_GND | NUM_SW'(1) << SW_F2T_POS;

  function automatic logic [NUM_SW-1:0] phase_cfg(input int unsigned ph);
    case (ph)
      0, 2:    phase_cfg = CFG_STORE;
      1:       phase_cfg = CFG_NEG_XFER;
      default: phase_cfg = CFG_POS_XFER;
    endcase
  endfunction
endpackage

// File: rtl/cp_seq_fsm.sv
module cp_seq_fsm
  import cp_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  shdn_i,
  input  logic                  need_i,
  output logic [NUM_PHASES-1:0] phase_oh_o,
  output logic                  active_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);

  seq_state_e      state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    if (shdn_i) begin
      state_d = ST_IDLE;
      ph_d    = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (tick_i && need_i) begin
          state_d = ST_DEAD;
          ph_d    = '0;
        end
        ST_DEAD: state_d = ST_DRIVE;
        ST_DRIVE: if (tick_i) begin
          if (ph_q != LAST_PH) begin
            state_d = ST_DEAD;
            ph_d    = ph_q + 1'b1;
          end else if (need_i) begin
            state_d = ST_DEAD;
            ph_d    = '0;
          end else begin
            state_d = ST_IDLE;
            ph_d    = '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_oh
    assign phase_oh_o[g] = (state_q == ST_DRIVE) && (ph_q == PH_W'(g));
  end

  assign active_o = (state_q != ST_IDLE);
endmodule

// File: rtl/cp_sw_decode.sv
module cp_sw_decode
  import cp_pkg::*;
(
  input  logic [NUM_PHASES-1:0] phase_oh_i,
  output logic [NUM_SW-1:0]     sw_o
);
  logic [NUM_SW-1:0] term [NUM_PHASES];

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_term
    assign term[g] = phase_oh_i[g] ? phase_cfg(g) : '0;
  end

  always_comb begin
    sw_o = '0;
    for (int i = 0; i < NUM_PHASES; i++) sw_o = sw_o | term[i];
  end
endmodule

// File: rtl/cp_ready_timer.sv
module cp_ready_timer #(
  parameter int unsigned READY_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic shdn_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(READY_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(READY_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (shdn_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/cp_phase_seq.sv
module cp_phase_seq
  import cp_pkg::*;
#(
  parameter int unsigned READY_TICKS = 50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  shdn_i,
  input  logic                  pos_ok_i,
  input  logic                  neg_ok_i,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic [NUM_SW-1:0]     sw_o,
  output logic                  pump_active_o,
  output logic                  pump_ready_o
);
  logic need;
  assign need = !(pos_ok_i && neg_ok_i);

  cp_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .shdn_i     (shdn_i),
    .need_i     (need),
    .phase_oh_o (phase_o),
    .active_o   (pump_active_o)
  );

  cp_sw_decode u_dec (
    .phase_oh_i (phase_o),
    .sw_o       (sw_o)
  );

  cp_ready_timer #(.READY_TICKS(READY_TICKS)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .shdn_i  (shdn_i),
    .ready_o (pump_ready_o)
  );
endmodule

// File: rtl/cp_phase_seq_chk.sv
module cp_phase_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       shdn_i,
  input logic [3:0] phase_o,
  input logic [7:0] sw_o,
  input logic       pump_active_o,
  input logic       pump_ready_o
);
  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_o));

  a_r4_dead_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 4'b0) |=> (phase_o == 4'b0 || $stable(phase_o)));

  a_r2_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 4'b0 && !tick_i && !shdn_i) |=> $stable(phase_o));

  a_r3_sw_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'b0) |-> (sw_o == 8'h00));

  a_r5_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 4'b0) |-> pump_active_o);

  a_r7_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> (phase_o == 4'b0 && !pump_active_o && !pump_ready_o));
endmodule

bind cp_phase_seq cp_phase_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .shdn_i        (shdn_i),
  .phase_o       (phase_o),
  .sw_o          (sw_o),
  .pump_active_o (pump_active_o),
  .pump_ready_o  (pump_ready_o)
);

// File: tb/cp_phase_seq_test.sv
`timescale 1ns/1ps
module cp_phase_seq_test;
  localparam int RT = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, shdn = 1'b0, pos_ok = 1'b0, neg_ok = 1'b0;
  logic [3:0] phase;
  logic [7:0] sw;
  logic active, ready;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // model state: 0 idle, 1 dead, 2 drive
  int m_st = 0, m_ph = 0, m_cnt = 0;

  always #4 clk = ~clk;

  cp_phase_seq #(.READY_TICKS(RT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .shdn_i(shdn),
    .pos_ok_i(pos_ok), .neg_ok_i(neg_ok), .phase_o(phase), .sw_o(sw),
    .pump_active_o(active), .pump_ready_o(ready)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_cnt = 0;
    end else begin
      if (shdn) begin
        m_st = 0; m_ph = 0; m_cnt = 0;
      end else begin
        if (tick && m_cnt < RT) m_cnt++;
        case (m_st)
          0: if (tick && !(pos_ok && neg_ok)) begin m_st = 1; m_ph = 0; end
          1: m_st = 2;
          default: if (tick) begin
            if (m_ph < 3) begin m_st = 1; m_ph++; end
            else if (!(pos_ok && neg_ok)) begin m_st = 1; m_ph = 0; end
            else begin m_st = 0; m_ph = 0; end
          end
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_sw(int st, int ph);
    if (st != 2) return 8'h00;
    case (ph)
      1: return 8'h33;
      3: return 8'hC3;
      default: return 8'h0C;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R2 R4 phase", phase, (m_st == 2) ? (1 << m_ph) : 0);
    chk("R3 switches", sw, exp_sw(m_st, m_ph));
    chk("R5 R6 R9 active", active, (m_st != 0));
    chk("R8 ready", ready, (m_cnt == RT));
  end

  task automatic run(int n, int per, bit p, bit q, bit s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      tick = (per > 0) && (i % per == per - 1);
      pos_ok = p; neg_ok = q; shdn = s;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {phase, sw, active, ready}, 0);
    #1 rst_n = 1'b1;
    run(5, 0, 0, 0, 0);
    chk("R1 idle after reset", {phase, sw, active, ready}, 0);
    run(40, 1, 0, 0, 0);          // tick every clock
    run(100, 5, 1, 0, 0);         // sparse ticks, positive in regulation
    run(9, 5, 0, 1, 0);           // into phase 2
    run(60, 5, 1, 1, 0);          // R6 regulation mid-cycle
    run(30, 2, 1, 1, 0);          // R9 ticks while idle, rails fine
    run(23, 3, 0, 0, 0);
    run(20, 1, 0, 0, 1);          // R7 shutdown mid-cycle with ticks
    run(200, 3, 0, 1, 0);         // R8 recovery count
    run(7, 4, 0, 0, 1);
    run(RT * 2, 1, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      tick   = ($urandom % 3) == 0;
      pos_ok = ($urandom % 4) != 0;
      neg_ok = ($urandom % 4) != 0;
      shdn   = ($urandom % 97) == 0;
    end
    run(10, 0, 1, 1, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule